// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block takes one stereo sample pair at a time, two signed 24-bit words, over a valid/ready handshake. It sends the pair out as a serial bit stream on one data line. The stream is framed by a bit clock and a left/right clock. A two-bit select picks one of four framings: right-justified, left-justified, I2S, or a DSP framing in which one short frame pulse starts the frame and the right word follows the left word with no gap. All four framings come from one slot counter and one bit selector.

In clock-master mode the block divides its own clock, which is the audio master clock, down to a bit clock and a 64-slot frame. The divisor is 4 for the 256-times-sample-rate case and 2 for the 128-times case. In clock-slave mode the block synchronises externally supplied bit and left/right clocks into its own clock domain. It locks its slot counter to the observed frame boundaries. It predicts each following slot so that the first bit of a half-frame is ready before that half-frame starts. A pair is taken from the one-deep input buffer only at a frame boundary. When no new pair has arrived, the previous pair is sent again.

Top module: `audio_serial_tx`

## Requirements
- R1: While `rst` is high, `sdata`, `bclk_out` and `lrclk_out` are 0 and `in_ready` is 1.
- R2: In master mode `bclk_out` has a period of 4 `clk` cycles when `rate_quad`=0 and 2 cycles when `rate_quad`=1. A frame is 64 bit-clock periods. `sdata` and `lrclk_out` change only in the cycle where `bclk_out` falls.
- R3: In master mode `lrclk_out`, seen at bit-clock rising edges in slot s (0..63, where slot 0 starts the left half), is: 1 for s<32 in the right-justified and left-justified framings; 1 for s>=32 in I2S; 1 only for s=0 in DSP.
- R4: Left-justified framing: the left word sits in slots 0..23 and the right word in slots 32..55, MSB first. All other slots carry 0.
- R5: I2S framing: the left word sits in slots 1..24 and the right word in slots 33..56, MSB first. All other slots carry 0.
- R6: Right-justified framing: the left word sits in slots 8..31 and the right word in slots 40..63, MSB first, so each LSB is in the last slot of its half. All other slots carry 0.
- R7: DSP framing: the left word sits in slots 1..24 and the right word in slots 25..48, MSB first. Slots 0 and 49..63 carry 0.
- R8: The `fmt_sel` encoding is 00 right-justified, 01 left-justified, 10 I2S, 11 DSP.
- R9: `in_ready` is 1 exactly when the one-entry buffer is empty. An accepted pair drops `in_ready` in the next cycle and stays pending until the next frame boundary.
- R10: A frame that starts while no new pair is pending repeats the previous pair bit for bit.
- R11: In slave mode `bclk_out` and `lrclk_out` stay 0 and the slot timing follows `bclk_in`/`lrclk_in`. `sdata` stays 0 until the first start of a left half has been observed. A pair that is already pending is not taken before that point.
- R12: In slave DSP framing the frame pulse on `lrclk_in` may be several bit periods wide. Only its rising edge sets the frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the master clock in master mode, an oversampling clock in slave mode |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | 1 = block drives the bit and frame clocks, 0 = follows external clocks |
| rate_quad | input | 1 | Master mode: 1 selects a bit clock of clk/2, 0 selects clk/4 |
| fmt_sel | input | 2 | Framing select (R8 encoding) |
| in_valid | input | 1 | Sample pair on in_left/in_right is offered |
| in_ready | output | 1 | Buffer can accept a pair |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| bclk_in | input | 1 | External bit clock (slave mode) |
| lrclk_in | input | 1 | External left/right clock or frame pulse (slave mode) |
| bclk_out | output | 1 | Generated bit clock (master mode, else 0) |
| lrclk_out | output | 1 | Generated left/right clock or frame pulse (master mode, else 0) |
| sdata | output | 1 | Serial data, changes after bit-clock falling edges |

## Verification
The bench targets slot placement in each framing, one slot at a time. A one-slot error in the I2S or DSP offset would shift every word by a factor of two and show up as a full-frame mismatch. A wrong right-justified offset would leave the LSB out of the last slot. Corner words 0x800000, 0x7FFFFF and alternating bit patterns expose swapped channels or bit order. In slave mode the bench checks that the first frame stays silent even though a pair is already pending, and that a several-bit-wide DSP pulse does not restart the frame. The bench also repeats frames without new input, to catch a design that sends stale zeros or drops the held pair.

// File: rtl/audio_tx_pkg.sv
`timescale 1ns/1ps
package audio_tx_pkg;

    localparam int WORD_W     = 24;
    localparam int FRAME_BITS = 64;
    localparam int HALF_BITS  = FRAME_BITS / 2;
    localparam int SLOT_W     = $clog2(FRAME_BITS);
    localparam int IDX_W      = $clog2(WORD_W);

    typedef enum logic [1:0] {
        FMT_RJ  = 2'b00,
        FMT_LJ  = 2'b01,
        FMT_I2S = 2'b10,
        FMT_DSP = 2'b11
    } fmt_e;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t left;
        word_t right;
    } pair_t;

    typedef logic [SLOT_W-1:0] slot_t;

    // First slot of the left word for each framing
    function automatic int left_first(fmt_e f);
        case (f)
            FMT_RJ:  return HALF_BITS - WORD_W;
            FMT_LJ:  return 0;
            default: return 1;
        endcase
    endfunction

    // First slot of the right word for each framing
    function automatic int right_first(fmt_e f);
        case (f)
            FMT_RJ:  return FRAME_BITS - WORD_W;
            FMT_LJ:  return HALF_BITS;
            FMT_I2S: return HALF_BITS + 1;
            default: return 1 + WORD_W;
        endcase
    endfunction

    // Bit carried by a given slot; 0 in unused slots
    function automatic logic slot_bit(fmt_e f, slot_t slot, pair_t p);
        int s;
        int lo;
        int ro;
        logic b;
        logic [IDX_W-1:0] idx;
        s  = int'(slot);
        lo = left_first(f);
        ro = right_first(f);
        b  = 1'b0;
        if (s >= lo && s < lo + WORD_W) begin
            idx = IDX_W'(WORD_W - 1 - (s - lo));
            b   = p.left[idx];
        end else if (s >= ro && s < ro + WORD_W) begin
            idx = IDX_W'(WORD_W - 1 - (s - ro));
            b   = p.right[idx];
        end
        return b;
    endfunction

    // Level of the frame clock during the left half
    function automatic logic left_level(fmt_e f);
        return (f != FMT_I2S);
    endfunction

    // Generated frame clock level for a slot in master mode
    function automatic logic master_lr(fmt_e f, slot_t slot);
        case (f)
            FMT_DSP: return (slot == '0);
            FMT_I2S: return (int'(slot) >= HALF_BITS);
            default: return (int'(slot) < HALF_BITS);
        endcase
    endfunction

endpackage

// File: rtl/audio_bclk_ctrl.sv
`timescale 1ns/1ps
module audio_bclk_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic master_en,
    input  logic rate_quad,
    input  logic bclk_in,
    input  logic lrclk_in,
    output logic fall_ev,
    output logic rise_ev,
    output logic lr_sync,
    output logic bclk_gen
);
    // Master divider
    logic [1:0] div_cnt;
    logic [1:0] cnt_last;
    logic [1:0] cnt_half;
    logic [1:0] cnt_next;
    logic       bclk_q;

    assign cnt_last = rate_quad ? 2'd1 : 2'd3;
    assign cnt_half = rate_quad ? 2'd1 : 2'd2;
    assign cnt_next = (div_cnt == cnt_last) ? 2'd0 : div_cnt + 2'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            bclk_q  <= 1'b0;
        end else begin
            div_cnt <= cnt_next;
            bclk_q  <= master_en && (cnt_next >= cnt_half);
        end
    end

    // Slave synchronisers; one extra bit clock stage for edge detection
    logic [SYNC_STAGES:0]   b_sh;
    logic [SYNC_STAGES-1:0] l_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            b_sh <= '0;
            l_sh <= '0;
        end else begin
            b_sh <= {b_sh[SYNC_STAGES-1:0], bclk_in};
            l_sh <= {l_sh[SYNC_STAGES-2:0], lrclk_in};
        end
    end

    logic b_new;
    logic b_old;
    assign b_new = b_sh[SYNC_STAGES-1];
    assign b_old = b_sh[SYNC_STAGES];

    assign fall_ev  = master_en ? (div_cnt == cnt_last) : (!b_new && b_old);
    assign rise_ev  = !master_en && b_new && !b_old;
    assign lr_sync  = l_sh[SYNC_STAGES-1];
    assign bclk_gen = bclk_q;

endmodule

// File: rtl/audio_pair_buffer.sv
`timescale 1ns/1ps
module audio_pair_buffer
    import audio_tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  word_t in_left,
    input  word_t in_right,
    output logic  in_ready,
    input  logic  take,
    output pair_t active
);
    pair_t pend_q;
    pair_t cur_q;
    logic  pend_v;

    assign in_ready = !pend_v;
    // Pair to use for the slot being prepared
    assign active = (take && pend_v) ? pend_q : cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            cur_q  <= '0;
            pend_v <= 1'b0;
        end else begin
            if (take && pend_v) begin
                cur_q  <= pend_q;
                pend_v <= 1'b0;
            end
            if (in_valid && !pend_v) begin
                pend_q <= '{left: in_left, right: in_right};
                pend_v <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/audio_slot_serializer.sv
`timescale 1ns/1ps
module audio_slot_serializer
    import audio_tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  fmt_e  fmt,
    input  logic  master_en,
    input  logic  fall_ev,
    input  logic  rise_ev,
    input  logic  lr_sync,
    input  pair_t active,
    output logic  take,
    output logic  sdata,
    output logic  lrclk_out
);
    slot_t slot_q;
    slot_t nslot;
    logic  locked_q;
    logic  prev_lr;
    logic  en;

    assign nslot = slot_q + 1'b1;
    assign en    = master_en || locked_q;
    assign take  = fall_ev && (nslot == '0) && en;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q    <= slot_t'(FRAME_BITS - 1);
            sdata     <= 1'b0;
            lrclk_out <= 1'b0;
            locked_q  <= 1'b0;
            prev_lr   <= 1'b0;
        end else begin
            if (fall_ev) begin
                slot_q    <= nslot;
                sdata     <= en ? slot_bit(fmt, nslot, active) : 1'b0;
                lrclk_out <= master_en ? master_lr(fmt, nslot) : 1'b0;
            end
            // Slave: realign the slot count on observed boundaries
            if (rise_ev) begin
                prev_lr <= lr_sync;
                if (fmt == FMT_DSP) begin
                    if (lr_sync && !prev_lr) begin
                        slot_q   <= '0;
                        locked_q <= 1'b1;
                    end
                end else if (lr_sync != prev_lr) begin
                    if (lr_sync == left_level(fmt)) begin
                        slot_q   <= '0;
                        locked_q <= 1'b1;
                    end else begin
                        slot_q <= slot_t'(HALF_BITS);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/audio_serial_tx.sv
`timescale 1ns/1ps
module audio_serial_tx
    import audio_tx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_en,
    input  logic              rate_quad,
    input  logic [1:0]        fmt_sel,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_left,
    input  logic [WORD_W-1:0] in_right,
    input  logic              bclk_in,
    input  logic              lrclk_in,
    output logic              bclk_out,
    output logic              lrclk_out,
    output logic              sdata
);
    logic  fall_ev;
    logic  rise_ev;
    logic  lr_sync;
    logic  take;
    pair_t active;

    audio_bclk_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .master_en(master_en),
        .rate_quad(rate_quad),
        .bclk_in  (bclk_in),
        .lrclk_in (lrclk_in),
        .fall_ev  (fall_ev),
        .rise_ev  (rise_ev),
        .lr_sync  (lr_sync),
        .bclk_gen (bclk_out)
    );

    audio_pair_buffer u_buf (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .in_left (in_left),
        .in_right(in_right),
        .in_ready(in_ready),
        .take    (take),
        .active  (active)
    );

    audio_slot_serializer u_ser (
        .clk      (clk),
        .rst      (rst),
        .fmt      (fmt_e'(fmt_sel)),
        .master_en(master_en),
        .fall_ev  (fall_ev),
        .rise_ev  (rise_ev),
        .lr_sync  (lr_sync),
        .active   (active),
        .take     (take),
        .sdata    (sdata),
        .lrclk_out(lrclk_out)
    );

endmodule

// File: rtl/audio_serial_tx_checker.sv
`timescale 1ns/1ps
module audio_serial_tx_checker (
    input logic clk,
    input logic rst,
    input logic master_en,
    input logic rate_quad,
    input logic in_valid,
    input logic in_ready,
    input logic bclk_out,
    input logic lrclk_out,
    input logic sdata
);
    p_sdata_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        (master_en && !$stable(sdata)) |-> $fell(bclk_out));

    p_lrclk_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (master_en && !$stable(lrclk_out)) |-> $fell(bclk_out));

    p_quad_toggle_r2: assert property (@(posedge clk) disable iff (rst)
        (master_en && rate_quad && !$past(rst)) |-> (bclk_out != $past(bclk_out)));

    p_ready_drops_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    p_slave_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !master_en |-> (!bclk_out && !lrclk_out));

endmodule

bind audio_serial_tx audio_serial_tx_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .master_en(master_en),
    .rate_quad(rate_quad),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .bclk_out (bclk_out),
    .lrclk_out(lrclk_out),
    .sdata    (sdata)
);

// File: tb/audio_serial_tx_bench.sv
`timescale 1ns/1ps
module audio_serial_tx_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        master_en = 1'b1;
    logic        rate_quad = 1'b0;
    logic [1:0]  fmt_sel = 2'b01;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_left = '0;
    logic [23:0] in_right = '0;
    logic        bclk_in = 1'b0;
    logic        lrclk_in = 1'b0;
    logic        bclk_out;
    logic        lrclk_out;
    logic        sdata;

    always #2.5 clk = ~clk;

    audio_serial_tx u_audio_serial_tx (
        .clk      (clk),
        .rst      (rst),
        .master_en(master_en),
        .rate_quad(rate_quad),
        .fmt_sel  (fmt_sel),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_left  (in_left),
        .in_right (in_right),
        .bclk_in  (bclk_in),
        .lrclk_in (lrclk_in),
        .bclk_out (bclk_out),
        .lrclk_out(lrclk_out),
        .sdata    (sdata)
    );

    int errors = 0;
    int checks = 0;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected frame, bit index = slot (R4..R8)
    function automatic logic [63:0] exp_frame(logic [1:0] f, logic [23:0] l, logic [23:0] r);
        logic [63:0] v;
        int lo;
        int ro;
        v = '0;
        case (f)
            2'b00:   begin lo = 8; ro = 40; end
            2'b01:   begin lo = 0; ro = 32; end
            2'b10:   begin lo = 1; ro = 33; end
            default: begin lo = 1; ro = 25; end
        endcase
        for (int k = 0; k < 24; k++) begin
            v[lo + k] = l[23 - k];
            v[ro + k] = r[23 - k];
        end
        return v;
    endfunction

    function automatic logic exp_lr(logic [1:0] f, int s);
        if (f == 2'b11) return (s == 0);
        if (f == 2'b10) return (s >= 32);
        return (s < 32);
    endfunction

    function automatic string fmt_req(logic [1:0] f);
        case (f)
            2'b00:   return "R6 R8 right-justified";
            2'b01:   return "R4 R8 left-justified";
            2'b10:   return "R5 R8 i2s";
            default: return "R7 R8 dsp";
        endcase
    endfunction

    // Slave clock generator state
    bit          s_run = 0;
    int          sc = 0;
    int          bs = 63;
    int          dspw = 5;
    int          s_frames = 0;
    logic [63:0] s_cap = '0;
    logic [63:0] s_last = '0;

    function automatic logic ext_lr(logic [1:0] f, int s);
        if (f == 2'b11) return (s < dspw);   // R12 wide pulse
        if (f == 2'b10) return (s >= 32);
        return (s < 32);
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            if (s_run) begin
                if (sc == 0) begin
                    bclk_in  = 1'b0;
                    bs       = (bs + 1) % 64;
                    lrclk_in = ext_lr(fmt_sel, bs);
                end else if (sc == 8) begin
                    bclk_in   = 1'b1;
                    s_cap[bs] = sdata;
                    if (bs == 63) begin
                        s_last = s_cap;
                        s_frames++;
                    end
                end
                sc = (sc + 1) % 16;
            end
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(!sdata && !bclk_out && !lrclk_out && in_ready, "R1 reset state",
            {60'd0, sdata, bclk_out, lrclk_out, in_ready}, 64'h1);
        rst = 1'b0;
    endtask

    task automatic push(logic [23:0] l, logic [23:0] r);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_left  = l;
        in_right = r;
        @(negedge clk);
        in_valid = 1'b0;
        chk(!in_ready, "R9 ready drops after accept", {63'd0, in_ready}, 64'd0);
    endtask

    task automatic wait_ready();
        while (!in_ready) @(negedge clk);
    endtask

    // Capture one master frame starting at slot 0
    task automatic cap_master(output logic [63:0] bits, output int lr_bad,
                              output int per, output int flen);
        logic pb;
        logic plr;
        int   since;
        bit   found;
        int   slot;
        bit   start;
        pb = bclk_out; plr = lrclk_out; since = 0; found = 0; slot = 0;
        bits = '0; lr_bad = 0; per = 0; flen = -1;
        forever begin
            @(negedge clk);
            since++;
            if (bclk_out && !pb) begin
                per   = since;
                since = 0;
                start = (fmt_sel == 2'b10) ? (!lrclk_out && plr) : (lrclk_out && !plr);
                if (found && slot == 64) begin
                    flen = start ? 64 : -1;
                    break;
                end
                if (!found && start) found = 1;
                if (found) begin
                    bits[slot] = sdata;
                    if (lrclk_out != exp_lr(fmt_sel, slot)) lr_bad++;
                    slot++;
                end
                plr = lrclk_out;
            end
            pb = bclk_out;
        end
    endtask

    task automatic run_master(logic [1:0] f, logic quad, logic [23:0] l1, logic [23:0] r1,
                              logic [23:0] l2, logic [23:0] r2);
        logic [63:0] bits;
        logic [63:0] first;
        int lr_bad;
        int per;
        int flen;
        s_run = 0;
        master_en = 1'b1;
        rate_quad = quad;
        fmt_sel = f;
        do_reset();
        push(l1, r1);
        wait_ready();
        cap_master(bits, lr_bad, per, flen);
        chk(bits == exp_frame(f, l1, r1), fmt_req(f), bits, exp_frame(f, l1, r1));
        chk(lr_bad == 0, "R3 frame clock level per slot", 64'(lr_bad), 64'd0);
        chk(per == (quad ? 2 : 4), "R2 bit clock period", 64'(per), quad ? 64'd2 : 64'd4);
        chk(flen == 64, "R2 frame length", 64'(flen), 64'd64);
        first = bits;
        cap_master(bits, lr_bad, per, flen);
        chk(bits == first, "R10 repeat held pair", bits, first);
        push(l2, r2);
        wait_ready();
        cap_master(bits, lr_bad, per, flen);
        chk(bits == exp_frame(f, l2, r2), fmt_req(f), bits, exp_frame(f, l2, r2));
    endtask

    task automatic run_slave(logic [1:0] f, logic [23:0] l, logic [23:0] r);
        logic [63:0] third;
        s_run = 0;
        master_en = 1'b0;
        rate_quad = 1'b0;
        fmt_sel = f;
        bclk_in = 1'b0;
        lrclk_in = 1'b0;
        do_reset();
        push(l, r);
        bs = 63;
        sc = 0;
        s_frames = 0;
        lrclk_in = ext_lr(f, 63);
        s_run = 1;
        while (s_frames < 1) @(negedge clk);
        chk(s_last == 64'd0, "R11 silent before lock", s_last, 64'd0);
        chk(!bclk_out && !lrclk_out, "R11 clock outputs low in slave",
            {62'd0, bclk_out, lrclk_out}, 64'd0);
        while (s_frames < 3) @(negedge clk);
        third = s_last;
        chk(third == exp_frame(f, l, r),
            (f == 2'b11) ? "R12 R7 slave dsp wide pulse" : "R11 slave framing",
            third, exp_frame(f, l, r));
        chk(in_ready, "R9 pending pair consumed", {63'd0, in_ready}, 64'd1);
        while (s_frames < 4) @(negedge clk);
        chk(s_last == third, "R10 slave repeat", s_last, third);
        s_run = 0;
        @(negedge clk);
        bclk_in = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int f = 0; f < 4; f++) begin
            run_master(2'(f), 1'b0, 24'($urandom), 24'($urandom), 24'h800000, 24'h7FFFFF);
        end
        run_master(2'b01, 1'b1, 24'hAAAAAA, 24'h555555, 24'($urandom), 24'($urandom));
        run_master(2'b11, 1'b1, 24'hFFFFFF, 24'h000001, 24'h000001, 24'hFFFFFF);
        run_master(2'b00, 1'b1, 24'($urandom), 24'($urandom), 24'hC00003, 24'h3FFFFC);
        for (int f = 0; f < 4; f++) begin
            run_slave(2'(f), 24'($urandom) | 24'h800001, 24'($urandom) | 24'h000001);
        end
        summary();
        $finish;
    end

endmodule